// File: doc/BRIEF.md
# Per-CPU Interrupt Level Register

This block is the per-processor slice of a multiprocessor interrupt system. It holds one pending word for its CPU and turns that word, plus hard-interrupt levels delivered by the system router, into a vector of fifteen level requests for levels 1 to 15.

The pending word gathers three kinds of source:

- Software interrupts for levels 1 to 15, stored in the upper half of the word.
- A private timer input.
- A level-15 input shared by all CPUs.

Software reaches the word through a small word-addressed register port:

- One word reads the pending state back.
- One word clears bits.
- One word sets software interrupts.

A global-disable flag from the router suppresses the timer and level-15 sources without clearing them. While the CPU is the router's current target, the readback word also shows the raw hard-interrupt levels, so software can see which system levels are active.

Level requests are registered. They follow the pending state one clock after any write or input change.

Top module: `cpu_irq_slice`

## Requirements
- R1: The word index is `reg_addr[3:2]`. A read of word 0 returns the pending word on `reg_rdata` in the cycle after the strobe. A read of words 1, 2 or 3 returns 0. `reg_rdata` is 0 in any cycle that does not follow a read strobe.
- R2: A write to word 1 clears each pending bit in 31..17 and bit 15 whose write-data bit is 1. All other write-data bits are ignored.
- R3: A write to word 2 sets each pending bit in 31..17 whose write-data bit is 1. Write-data bits 16..0 are ignored, and writes to words 0 and 3 change nothing.
- R4: Pending bit 16+L, for L = 1..15, drives level request L, which is `lvl_req[L-1]`.
- R5: Pending bit 14 follows `timer_in`. Pending bit 15 is set when `lvl15_in` rises and cleared when it falls or when a word-1 write clears it.
- R6: Pending bit 14 drives level 14 (`lvl_req[13]`) and pending bit 15 drives level 15 (`lvl_req[14]`) only while `glob_dis` is 0. Their readback is unaffected by `glob_dis`.
- R7: `hw_req[L-1]` is ORed into `lvl_req[L-1]`. While `is_target` is 1, readback bit L is set for each `hw_raw[L-1]` that is 1. `hw_raw` never drives `lvl_req`.
- R8: Reset clears the pending word, `lvl_req` and `reg_rdata`.
- R9: `lvl_req` changes at the first clock edge that samples the write or input change, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe, one cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte address; bits 3:2 select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| timer_in | input | 1 | Private timer interrupt level |
| lvl15_in | input | 1 | Shared level-15 interrupt level |
| glob_dis | input | 1 | Global disable flag from the router |
| is_target | input | 1 | This CPU is the router's current target |
| hw_req | input | 15 | Masked hard-interrupt levels 1..15 routed to this CPU |
| hw_raw | input | 15 | Raw hard-interrupt levels 1..15, used for display only |
| lvl_req | output | 15 | Level requests; bit L-1 is level L |

## Verification
The bench pushes on the bit fences of the write words:

- Setting all 32 bits must leave bits 16..0 of the pending word clear.
- A clear must reach bit 15 but not bit 14.
- Write data below bit 17 sent to the set word must do nothing.

A design with a mask off by one bit would show stray readback bits or a level request one step away from the expected one.

The bench also holds the level-15 input high while software clears it. A design that simply copies the input would re-assert level 15 at once.

Finally, it raises the global disable while the timer is active. The level-14 request must drop, but the timer bit must stay visible in readback. A design that masked the pending bit itself, instead of the request, would lose that bit.

// File: rtl/cpu_irq_slice.sv
module cpu_irq_slice #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int NUM_LVL = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              timer_in,
  input  logic              lvl15_in,
  input  logic              glob_dis,
  input  logic              is_target,
  input  logic [NUM_LVL-1:0] hw_req,
  input  logic [NUM_LVL-1:0] hw_raw,
  output logic [NUM_LVL-1:0] lvl_req
);

  localparam int SOFT_LO = DATA_W - NUM_LVL;
  localparam int TMR_BIT = NUM_LVL - 1;
  localparam int L15_BIT = NUM_LVL;

  logic [NUM_LVL-1:0] soft_q, soft_nxt;
  logic               tmr_q, l15_q, l15_nxt, l15_prev;
  logic [1:0]         word;
  logic               wr_clr, wr_set, rd_w0, rd_any;
  logic [DATA_W-1:0]  pend_word, disp_word;
  logic [NUM_LVL-1:0] lvl_nxt;

  assign word   = reg_addr[3:2];
  assign wr_clr = reg_valid && reg_write && (word == 2'd1);
  assign wr_set = reg_valid && reg_write && (word == 2'd2);
  assign rd_any = reg_valid && !reg_write;
  assign rd_w0  = rd_any && (word == 2'd0);

  always_comb begin
    soft_nxt = soft_q;
    if (wr_clr) soft_nxt = soft_q & ~reg_wdata[DATA_W-1:SOFT_LO];
    if (wr_set) soft_nxt = soft_q | reg_wdata[DATA_W-1:SOFT_LO];
  end

  assign l15_nxt = (lvl15_in && !l15_prev) ||
                   (l15_q && lvl15_in && !(wr_clr && reg_wdata[L15_BIT]));

  always_comb begin
    lvl_nxt = soft_nxt | hw_req;
    if (!glob_dis) begin
      lvl_nxt[TMR_BIT-1] = lvl_nxt[TMR_BIT-1] | timer_in;
      lvl_nxt[TMR_BIT]   = lvl_nxt[TMR_BIT] | l15_nxt;
    end
  end

  always_comb begin
    pend_word = '0;
    pend_word[DATA_W-1:SOFT_LO] = soft_q;
    pend_word[TMR_BIT] = tmr_q;
    pend_word[L15_BIT] = l15_q;
  end

  always_comb begin
    disp_word = '0;
    if (is_target) disp_word[NUM_LVL:1] = hw_raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_q    <= '0;
      tmr_q     <= 1'b0;
      l15_q     <= 1'b0;
      l15_prev  <= 1'b0;
      lvl_req   <= '0;
      reg_rdata <= '0;
    end else begin
      soft_q    <= soft_nxt;
      tmr_q     <= timer_in;
      l15_q     <= l15_nxt;
      l15_prev  <= lvl15_in;
      lvl_req   <= lvl_nxt;
      reg_rdata <= rd_w0 ? (pend_word | disp_word) : '0;
    end
  end

  AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && word != 2'd0) |=> reg_rdata == '0); // R1
  AST_CLR_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (soft_q & $past(reg_wdata[DATA_W-1:SOFT_LO])) == '0); // R2
  AST_SET_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (lvl_req & $past(reg_wdata[DATA_W-1:SOFT_LO])) == $past(reg_wdata[DATA_W-1:SOFT_LO])); // R3
  AST_TMR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tmr_q == $past(timer_in)); // R5
  AST_DIS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    glob_dis |=> lvl_req[NUM_LVL-1:NUM_LVL-2] == (soft_q[NUM_LVL-1:NUM_LVL-2] | $past(hw_req[NUM_LVL-1:NUM_LVL-2]))); // R6

endmodule

// File: tb/cpu_irq_slice_tb_top.sv
module cpu_irq_slice_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        timer_in = 1'b0, lvl15_in = 1'b0, glob_dis = 1'b0, is_target = 1'b0;
  logic [14:0] hw_req = '0, hw_raw = '0;
  logic [14:0] lvl_req;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cpu_irq_slice dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .timer_in(timer_in), .lvl15_in(lvl15_in), .glob_dis(glob_dis),
    .is_target(is_target), .hw_req(hw_req), .hw_raw(hw_raw), .lvl_req(lvl_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d = reg_rdata;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R8 lvl_req", {17'd0, lvl_req}, 32'h0);
    chk("R8 rdata", reg_rdata, 32'h0);
    rd(4'h0, d);
    chk("R8 pending", d, 32'h0);
  endtask

  task automatic t_set();
    logic [31:0] d;
    wr(4'h8, 32'hFFFF_FFFF);
    chk("R9 lvl after set", {17'd0, lvl_req}, 32'h7FFF);
    rd(4'h0, d);
    chk("R3 set fence", d, 32'hFFFE_0000);
    step();
    chk("R1 rdata idle", reg_rdata, 32'h0);
  endtask

  task automatic t_ignored_words();
    logic [31:0] d;
    rd(4'h4, d); chk("R1 word1 read", d, 32'h0);
    rd(4'h8, d); chk("R1 word2 read", d, 32'h0);
    rd(4'hC, d); chk("R1 word3 read", d, 32'h0);
    wr(4'h0, 32'h0);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R3 words0/3 no effect", d, 32'hFFFE_0000);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(4'h4, 32'h8002_0000);
    chk("R4 lvl after clear", {17'd0, lvl_req}, 32'h3FFE);
    rd(4'h0, d); chk("R2 clear picked", d, 32'h7FFC_0000);
    wr(4'h4, 32'hFFFF_FFFF);
    chk("R2 clear all lvl", {17'd0, lvl_req}, 32'h0);
    wr(4'h8, 32'h0001_FFFF);
    rd(4'h0, d); chk("R3 low set bits ignored", d, 32'h0);
    wr(4'h8, 32'h0004_0000);
    chk("R4 soft bit18 -> level2", {17'd0, lvl_req}, 32'h0002);
    wr(4'h4, 32'h0004_0000);
  endtask

  task automatic t_timer();
    logic [31:0] d;
    @(negedge clk); timer_in = 1'b1;
    chk("R9 no early change", {17'd0, lvl_req}, 32'h0);
    @(negedge clk);
    chk("R6 timer level14", {17'd0, lvl_req}, 32'h2000);
    rd(4'h0, d); chk("R5 timer bit14", d, 32'h0000_4000);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R2 bit14 not clearable", d, 32'h0000_4000);
    @(negedge clk); glob_dis = 1'b1;
    @(negedge clk);
    chk("R6 disable masks timer", {17'd0, lvl_req}, 32'h0);
    rd(4'h0, d); chk("R6 timer still visible", d, 32'h0000_4000);
    @(negedge clk); glob_dis = 1'b0; timer_in = 1'b0;
    @(negedge clk);
    rd(4'h0, d); chk("R5 timer follows low", d, 32'h0);
    chk("R5 timer lvl low", {17'd0, lvl_req}, 32'h0);
  endtask

  task automatic t_lvl15();
    logic [31:0] d;
    @(negedge clk); lvl15_in = 1'b1;
    @(negedge clk);
    chk("R6 lvl15 request", {17'd0, lvl_req}, 32'h4000);
    rd(4'h0, d); chk("R5 lvl15 bit15", d, 32'h0000_8000);
    wr(4'h4, 32'h0000_8000);
    chk("R2 clear bit15 lvl", {17'd0, lvl_req}, 32'h0);
    step(); step();
    rd(4'h0, d); chk("R5 stays cleared while high", d, 32'h0);
    @(negedge clk); lvl15_in = 1'b0;
    @(negedge clk); lvl15_in = 1'b1;
    @(negedge clk);
    rd(4'h0, d); chk("R5 re-rise sets bit15", d, 32'h0000_8000);
    @(negedge clk); lvl15_in = 1'b0;
    @(negedge clk);
    rd(4'h0, d); chk("R5 falls clears bit15", d, 32'h0);
  endtask

  task automatic t_hard();
    logic [31:0] d;
    @(negedge clk); hw_req = 15'h0005;
    @(negedge clk);
    chk("R7 hw_req merged", {17'd0, lvl_req}, 32'h0005);
    @(negedge clk); hw_req = '0; hw_raw = 15'h0003; is_target = 1'b1;
    @(negedge clk);
    chk("R7 raw not requested", {17'd0, lvl_req}, 32'h0);
    rd(4'h0, d); chk("R7 raw display target", d, 32'h0000_0006);
    @(negedge clk); is_target = 1'b0;
    rd(4'h0, d); chk("R7 raw hidden not target", d, 32'h0);
    hw_raw = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set();
    t_ignored_words();
    t_clear();
    t_timer();
    t_lvl15();
    t_hard();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule